// File: doc/BRIEF.md
# MDIO Station Management Master

This block is a serial management master that reads and writes registers inside external PHY devices over a two-wire bus. The bus has a clock line (MDC) and one shared bidirectional data line (MDIO). The block derives MDC from the system clock. MDC toggles only while a transaction is running and is held low at all other times. The block presents the data line as three separate signals: an output value, an output enable and an input. The pad buffer is outside the block.

A transaction starts when `cmd_valid` is pulsed while `busy` is low. On that request the block latches the direction, the 5-bit PHY address, the 5-bit register address and the write data, and then it runs one 64-bit clause 22 frame. A divider select field sets the MDC rate. Each step of that field adds one minimum half period, so every setting respects the 160 ns minimum high and low times and the 400 ns minimum period. Read results appear on `rd_data` when the frame ends.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0x0000.
- R2: When `cmd_valid` is 1 on a clock edge while `busy` is 0, the block accepts the command at that edge. `busy` is then high for exactly 128·H cycles. H is the half period, in system clock cycles, latched at that edge.
- R3: H = MIN_HALF·(div_sel+1). MIN_HALF is the smallest count of system cycles that gives at least 160 ns per level and at least 400 ns per MDC period (20 at 100 MHz). MDC rises H cycles after acceptance and then toggles every H cycles.
- R4: MDC is 0 in every cycle in which `busy` is 0.
- R5: Each frame bit is held on `mdio_o` for 2·H cycles. A bit starts at acceptance or at an MDC falling edge. Bits are sent MSB first in this order: 32 ones, start bits 0 then 1, opcode (1,0 for a read; 0,1 for a write), PHY address bits 4..0, register address bits 4..0, two turnaround bits, then 16 data bits.
- R6: In a write frame, `mdio_oe` is 1 for all 64 bits, the turnaround bits are 1 then 0, and the data bits are `cmd_wdata[15:0]`.
- R7: In a read frame, `mdio_oe` is 1 for bits 0 to 45 and 0 from the first turnaround bit (bit 46) to the end. `mdio_o` is 0 whenever `mdio_oe` is 0, and also whenever the block is idle.
- R8: In a read frame, `mdio_i` is sampled at the MDC rising edge of bits 48 to 63, and these samples form `rd_data[15]` down to `rd_data[0]`. `rd_data` changes only in the cycle in which `busy` falls at the end of a read frame.
- R9: A `cmd_valid` pulse while `busy` is 1 is ignored. The frame in progress continues unchanged and no further frame follows.
- R10: A change of `div_sel` while `busy` is 1 does not affect the frame in progress.
- R11: A write frame leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | DIV_W | MDC divider select; half period = MIN_HALF·(div_sel+1) |
| cmd_valid | input | 1 | Command request pulse |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Data returned by the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The reference model in the bench counts the edges t since acceptance. All results are due in the same cycle: `busy` is due one edge after the request, the MDC level after ⌊t/H⌋, the bit index after ⌊t/2H⌋, and `rd_data` at t = 128·H. The bench compares every output at each falling clock edge against these expected values. The PHY model changes `mdio_i` only on falling edges and selects each bit by the current bit index. Each read bit is therefore stable across the rising edge at which it must be sampled. Stray commands and divider changes are injected in the middle of frames, and the cycle-exact comparison shows that they have no effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int BIT_W      = 6;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int DATA_BITS  = 16;

    typedef struct packed {
        logic                  busy;
        logic                  is_read;
        logic                  oe;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_BITS-1:0]  rsh;
        logic [DATA_BITS-1:0]  rd;
    } seq_state_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        rd,
        input logic [4:0]  phy,
        input logic [4:0]  rg,
        input logic [15:0] wd
    );
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = rd ? 2'b10 : 2'b01;
        ta  = rd ? 2'b00 : 2'b10;
        dat = rd ? 16'h0000 : wd;
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W     = 3,
    parameter int MIN_HALF  = 20,
    parameter int HALF_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic              mdc;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       edge_now;

    assign edge_now = run && (st_q.cnt == st_q.half - HALF_W'(1));

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.mdc  = 1'b0;
            st_d.cnt  = '0;
            st_d.half = HALF_W'(MIN_HALF) * (HALF_W'(div_sel) + HALF_W'(1));
        end else if (!run) begin
            st_d.mdc = 1'b0;
            st_d.cnt = '0;
        end else if (edge_now) begin
            st_d.mdc = !st_q.mdc;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc  = st_q.mdc;
    assign rise = edge_now && !st_q.mdc;
    assign fall = edge_now && st_q.mdc;

    AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt < st_q.half)); // R3
    AST_HALF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(st_q.half)); // R10
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_read,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdc_lvl,
    input  logic        mdio_i,
    output logic        start,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    seq_state_t       st_d, st_q;
    logic [BIT_W-1:0] nxt_bit;

    assign start   = cmd_valid && !st_q.busy;
    assign nxt_bit = st_q.bitn + BIT_W'(1);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy    = 1'b1;
            st_d.is_read = cmd_read;
            st_d.oe      = 1'b1;
            st_d.bitn    = '0;
            st_d.sh      = build_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
        end else if (st_q.busy) begin
            if (rise && st_q.is_read && (st_q.bitn >= BIT_W'(DATA_FIRST))) begin
                st_d.rsh = {st_q.rsh[DATA_BITS-2:0], mdio_i};
            end
            if (fall) begin
                if (st_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.oe   = 1'b0;
                    if (st_q.is_read) begin
                        st_d.rd = st_q.rsh;
                    end
                end else begin
                    st_d.bitn = nxt_bit;
                    st_d.sh   = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                    st_d.oe   = !st_q.is_read || (nxt_bit < BIT_W'(TA_FIRST));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign mdio_oe = st_q.oe;
    assign mdio_o  = st_q.oe && st_q.sh[FRAME_BITS-1];
    assign rd_data = st_q.rd;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.oe); // R1
    AST_MDC_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> !mdc_lvl); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(st_q.busy) |-> $stable(st_q.rd)); // R8
    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.is_read)); // R9
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.is_read && st_q.bitn >= BIT_W'(TA_FIRST)) |-> !mdio_oe); // R7
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int CLK_NS        = 10,
    parameter int MIN_PULSE_NS  = 160,
    parameter int MIN_PERIOD_NS = 400,
    parameter int DIV_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [4:0]       cmd_phy,
    input  logic [4:0]       cmd_reg,
    input  logic [15:0]      cmd_wdata,
    output logic             busy,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int PULSE_CYC = (MIN_PULSE_NS + CLK_NS - 1) / CLK_NS;
    localparam int PER_CYC   = (MIN_PERIOD_NS + 2 * CLK_NS - 1) / (2 * CLK_NS);
    localparam int MIN_HALF  = (PULSE_CYC > PER_CYC) ? PULSE_CYC : PER_CYC;
    localparam int HALF_W    = $clog2(MIN_HALF * (2 ** DIV_W) + 1);

    logic start, rise, fall;

    mdio_clk_div #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF),
        .HALF_W   (HALF_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (busy),
        .div_sel (div_sel),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .rise      (rise),
        .fall      (fall),
        .mdc_lvl   (mdc),
        .mdio_i    (mdio_i),
        .start     (start),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data)
    );

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R4
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R9
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int MIN_HALF = 20; // 200 ns half period at 10 ns per cycle

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  div_sel = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    bit          m_active = 0;
    bit          m_isrd = 0;
    int          m_t = 0;
    int          m_h = MIN_HALF;
    logic [63:0] m_frame = '0;
    logic [15:0] m_rd = '0;
    logic [15:0] m_rdval = '0;
    logic [15:0] phy_value = '0;

    always #5 clk = !clk;

    mdio_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0;
            m_t = 0;
            m_rd = '0;
        end else if (m_active) begin
            m_t++;
            if (m_t == 128 * m_h) begin
                m_active = 0;
                if (m_isrd) m_rd = m_rdval;
            end
        end else if (cmd_valid) begin
            m_active = 1;
            m_t = 0;
            m_isrd = cmd_read;
            m_h = MIN_HALF * (int'(div_sel) + 1);
            m_rdval = phy_value;
            m_frame = {32'hFFFF_FFFF, 2'b01, cmd_read ? 2'b10 : 2'b01, cmd_phy, cmd_reg,
                       cmd_read ? 2'b00 : 2'b10, cmd_read ? 16'h0000 : cmd_wdata};
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, m_t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            int  b;
            bit  e_mdc, e_oe, e_o;
            b = m_t / (2 * m_h);
            e_mdc = m_active && (((m_t / m_h) % 2) == 1);
            e_oe  = m_active && (!m_isrd || b < 46);
            e_o   = e_oe && m_frame[63 - b];
            check("R2 busy", {15'd0, busy}, {15'd0, m_active});
            check(m_active ? "R3 mdc" : "R4 mdc", {15'd0, mdc}, {15'd0, e_mdc});
            check(m_isrd ? "R7 mdio_oe" : "R6 mdio_oe", {15'd0, mdio_oe}, {15'd0, e_oe});
            check(m_isrd ? "R7 mdio_o" : "R5 mdio_o", {15'd0, mdio_o}, {15'd0, e_o});
            check(m_isrd ? "R8 rd_data" : "R11 rd_data", rd_data, m_rd);
            if (m_active && m_isrd && b >= 48) mdio_i = m_rdval[63 - b];
            else mdio_i = 1'b1;
        end
    end

    task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [2:0] dv);
        @(negedge clk);
        cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd; div_sel = dv;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (m_active) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 idle busy", {15'd0, busy}, 16'd0);
        check("R1 idle oe", {15'd0, mdio_oe}, 16'd0);
        check("R1 idle rd", rd_data, 16'h0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R5 R6: write frame at the fastest divider
        issue(1'b0, 5'h1B, 5'h04, 16'hA5C3, 3'd0);
        // R9 R10: stray command and divider change during the frame
        repeat (300) @(negedge clk);
        cmd_read = 1'b1; cmd_phy = 5'h02; cmd_valid = 1'b1; div_sel = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        // R3 R7 R8: read frame with slower divider
        phy_value = 16'h3C96;
        issue(1'b1, 5'h00, 5'h1F, 16'h0000, 3'd1);
        wait_done();
        // R8: read with edge patterns
        phy_value = 16'h8001;
        issue(1'b1, 5'h1F, 5'h00, 16'hFFFF, 3'd0);
        repeat (2000) @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        // R11: write leaves rd_data
        issue(1'b0, 5'h15, 5'h0A, 16'h0000, 3'd0);
        wait_done();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule